// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Line-Break Detector

This block takes a raw asynchronous receive line, idle high, and recovers bytes sent as one low start bit, eight data bits with the least significant bit first, and two high stop bits with no parity. At the default bit rate of 250 kbit/s and a 16 MHz system clock, one bit lasts 64 clock cycles. The line passes through a two-flop synchroniser. A start bit is confirmed at its midpoint, and every later bit is sampled at its own midpoint. Only the first stop bit decides whether the byte carries a framing error.

Alongside the byte path, a separate timer measures how long the synchronised line stays continuously low. When that low stretch reaches the break threshold (960 cycles, 60 µs by default), the block emits a single reset-detected pulse. A held-low reset is therefore reported as its own event and not only as a damaged frame. The receiver rejects a line that is still low after a framing error as a new start bit. It re-arms only once the line has gone high again, so a long low yields exactly one erroneous zero byte.

Top module: `sbrx_top`

## Requirements
- R1: During and straight after synchronous reset, `byteValid`, `breakPulse`, `frameErr` are 0 and `rxByte` is 0x00.
- R2: A frame is received with its first data bit placed in bit 0 of `rxByte`; `byteValid` is high for exactly one clock cycle per frame.
- R3: A low level that has gone high again by the middle of the start-bit period is ignored and yields no byte.
- R4: If the first stop bit is sampled low, `frameErr` is 1 together with the byte; `rxByte` and `frameErr` hold their values until the next `byteValid`.
- R5: Frames sent back to back with exactly two stop bits between them are all received without error; only the first stop bit is checked.
- R6: A continuous low lasting `BREAK_CLKS` cycles of the synchronised line raises `breakPulse` for one cycle, and it does not fire again until the line has been high.
- R7: A low stretch shorter than `BREAK_CLKS` cycles, even one longer than a whole frame, raises no `breakPulse`.
- R8: After a framing error the receiver waits for a high level before it hunts for a start bit again, so one held-low reset produces exactly one byte 0x00 with `frameErr` = 1, and normal reception resumes afterwards.
- R9: When the break threshold falls on the cycle in which the first stop bit is judged, `byteValid` and `breakPulse` are both reported in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| rxLine | input | 1 | Raw asynchronous receive line, idle high |
| rxByte | output | 8 | Last received byte |
| byteValid | output | 1 | One-cycle strobe marking a new byte |
| frameErr | output | 1 | First stop bit was low; held with `rxByte` |
| breakPulse | output | 1 | One-cycle pulse when a low stretch reaches the break threshold |

## Verification
The framing-error byte and the break pulse come from separate logic, and they can land on the same clock edge. That happens when the break threshold equals the distance from the start-bit falling edge to the midpoint of the first stop bit, which is 609 cycles with default bit timing. A second instance with that threshold shares the stimulus line. For every break pulse that instance raises, the bench requires a byte strobe in the same cycle. The same long lows are also judged on the default instance, where the error byte comes well before the single break pulse.

// File: rtl/sbrx_pkg.sv
package sbrx_pkg;

  localparam int DEF_CLKS_PER_BIT = 64;
  localparam int DEF_BREAK_CLKS   = 960;
  localparam int DEF_DATA_BITS    = 8;
  localparam int DEF_SYNC_STAGES  = 2;

  // Strobes issued by the control FSM to the datapath
  typedef struct packed {
    logic clrTick;    // hold the bit-time counter at zero
    logic shiftBit;   // shift the synchronised line into the data register
    logic clrBitCnt;  // restart the data-bit counter
    logic loadOut;    // publish byte and framing flag
  } rxStrobes_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_STOP,
    ST_WAITHI
  } rxState_t;

endpackage

// File: rtl/sbrx_datapath.sv
module sbrx_datapath
  import sbrx_pkg::*;
#(
  parameter int CLKS_PER_BIT = DEF_CLKS_PER_BIT,
  parameter int DATA_BITS    = DEF_DATA_BITS,
  parameter int SYNC_STAGES  = DEF_SYNC_STAGES
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rxLine,
  input  rxStrobes_t           strb,
  output logic                 lineSync,
  output logic                 halfHit,
  output logic                 fullHit,
  output logic                 lastBit,
  output logic [DATA_BITS-1:0] rxByte,
  output logic                 byteValid,
  output logic                 frameErr
);

  localparam int HALF_BIT = CLKS_PER_BIT / 2;
  localparam int TICK_W   = $clog2(CLKS_PER_BIT);
  localparam int BIT_W    = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;

  logic [SYNC_STAGES-1:0] syncReg;
  logic [TICK_W-1:0]      tickCnt;
  logic [BIT_W-1:0]       bitCnt;
  logic [DATA_BITS-1:0]   shiftReg;

  // Synchroniser: idle level is high
  always_ff @(posedge clk) begin
    if (rst) syncReg <= '1;
    else     syncReg <= {syncReg[SYNC_STAGES-2:0], rxLine};
  end
  assign lineSync = syncReg[SYNC_STAGES-1];

  // Bit-time counter
  always_ff @(posedge clk) begin
    if (rst || strb.clrTick) tickCnt <= '0;
    else                     tickCnt <= tickCnt + 1'b1;
  end
  assign halfHit = (tickCnt == TICK_W'(HALF_BIT - 1));
  assign fullHit = (tickCnt == TICK_W'(CLKS_PER_BIT - 1));

  // Data-bit counter
  always_ff @(posedge clk) begin
    if (rst || strb.clrBitCnt) bitCnt <= '0;
    else if (strb.shiftBit)    bitCnt <= bitCnt + 1'b1;
  end
  assign lastBit = (bitCnt == BIT_W'(DATA_BITS - 1));

  // LSB arrives first: shift toward bit 0
  always_ff @(posedge clk) begin
    if (rst)               shiftReg <= '0;
    else if (strb.shiftBit) shiftReg <= {lineSync, shiftReg[DATA_BITS-1:1]};
  end

  // Output registers
  always_ff @(posedge clk) begin
    if (rst) begin
      rxByte    <= '0;
      frameErr  <= 1'b0;
      byteValid <= 1'b0;
    end else begin
      byteValid <= strb.loadOut;
      if (strb.loadOut) begin
        rxByte   <= shiftReg;
        frameErr <= ~lineSync;
      end
    end
  end

endmodule

// File: rtl/sbrx_control.sv
module sbrx_control
  import sbrx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       lineSync,
  input  logic       halfHit,
  input  logic       fullHit,
  input  logic       lastBit,
  output rxStrobes_t strb
);

  rxState_t state, nextState;

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= nextState;
  end

  always_comb begin
    nextState = state;
    strb      = '0;
    unique case (state)
      ST_IDLE: begin
        strb.clrTick   = 1'b1;
        strb.clrBitCnt = 1'b1;
        if (!lineSync) nextState = ST_START;
      end
      ST_START: begin
        if (halfHit) begin
          strb.clrTick = 1'b1;
          nextState    = lineSync ? ST_IDLE : ST_DATA;
        end
      end
      ST_DATA: begin
        if (fullHit) begin
          strb.clrTick  = 1'b1;
          strb.shiftBit = 1'b1;
          if (lastBit) nextState = ST_STOP;
        end
      end
      ST_STOP: begin
        if (fullHit) begin
          strb.clrTick = 1'b1;
          strb.loadOut = 1'b1;
          nextState    = lineSync ? ST_IDLE : ST_WAITHI;
        end
      end
      ST_WAITHI: begin
        strb.clrTick = 1'b1;
        if (lineSync) nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/sbrx_lowtimer.sv
module sbrx_lowtimer #(
  parameter int BREAK_CLKS = sbrx_pkg::DEF_BREAK_CLKS
) (
  input  logic clk,
  input  logic rst,
  input  logic lineSync,
  output logic breakPulse
);

  localparam int LOW_W = $clog2(BREAK_CLKS + 1);

  logic [LOW_W-1:0] lowCnt;

  // Saturating count of consecutive low cycles
  always_ff @(posedge clk) begin
    if (rst || lineSync)                        lowCnt <= '0;
    else if (lowCnt != LOW_W'(BREAK_CLKS))      lowCnt <= lowCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) breakPulse <= 1'b0;
    else     breakPulse <= ~lineSync && (lowCnt == LOW_W'(BREAK_CLKS - 1));
  end

endmodule

// File: rtl/sbrx_top.sv
module sbrx_top
  import sbrx_pkg::*;
#(
  parameter int CLKS_PER_BIT = DEF_CLKS_PER_BIT,
  parameter int BREAK_CLKS   = DEF_BREAK_CLKS
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rxLine,
  output logic [7:0] rxByte,
  output logic       byteValid,
  output logic       frameErr,
  output logic       breakPulse
);

  rxStrobes_t strb;
  logic lineSync, halfHit, fullHit, lastBit;

  sbrx_datapath #(
    .CLKS_PER_BIT(CLKS_PER_BIT),
    .DATA_BITS   (8),
    .SYNC_STAGES (DEF_SYNC_STAGES)
  ) dp_i (
    .clk      (clk),
    .rst      (rst),
    .rxLine   (rxLine),
    .strb     (strb),
    .lineSync (lineSync),
    .halfHit  (halfHit),
    .fullHit  (fullHit),
    .lastBit  (lastBit),
    .rxByte   (rxByte),
    .byteValid(byteValid),
    .frameErr (frameErr)
  );

  sbrx_control ctl_i (
    .clk     (clk),
    .rst     (rst),
    .lineSync(lineSync),
    .halfHit (halfHit),
    .fullHit (fullHit),
    .lastBit (lastBit),
    .strb    (strb)
  );

  sbrx_lowtimer #(
    .BREAK_CLKS(BREAK_CLKS)
  ) lt_i (
    .clk       (clk),
    .rst       (rst),
    .lineSync  (lineSync),
    .breakPulse(breakPulse)
  );

endmodule

// File: rtl/sbrx_checker.sv
module sbrx_checker (
  input logic       clk,
  input logic       rst,
  input logic       rxLine,
  input logic [7:0] rxByte,
  input logic       byteValid,
  input logic       frameErr,
  input logic       breakPulse
);

  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!byteValid && !breakPulse && !frameErr && rxByte == 8'h00));

  a_r2_valid_one_cycle: assert property (@(posedge clk) disable iff (rst)
    byteValid |=> !byteValid);

  a_r4_hold_between_bytes: assert property (@(posedge clk) disable iff (rst)
    !byteValid |-> ($stable(rxByte) && $stable(frameErr)));

  a_r6_break_single: assert property (@(posedge clk) disable iff (rst)
    breakPulse |=> !breakPulse);

  a_r6_break_after_low: assert property (@(posedge clk) disable iff (rst)
    breakPulse |-> !$past(rxLine, 3));

endmodule

bind sbrx_top sbrx_checker chk_i (
  .clk       (clk),
  .rst       (rst),
  .rxLine    (rxLine),
  .rxByte    (rxByte),
  .byteValid (byteValid),
  .frameErr  (frameErr),
  .breakPulse(breakPulse)
);

// File: tb/sbrx_top_tb_top.sv
module sbrx_top_tb_top;

  localparam int CLK_PERIOD = 62;
  localparam int BIT        = 64;
  localparam int COIN_BREAK = BIT / 2 + 1 + 9 * BIT;  // break lands on stop-bit judgement
  localparam int WATCHDOG   = 200000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rxLine = 1'b1;

  logic [7:0] rxByte, rxByte2;
  logic byteValid, frameErr, breakPulse;
  logic byteValid2, frameErr2, breakPulse2;

  int checks = 0;
  int fails  = 0;
  int validSeen = 0;
  int breakSeen = 0;
  int break2Seen = 0;
  int coinSeen = 0;
  bit done = 1'b0;
  logic [8:0] expQ[$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  sbrx_top dut_i (
    .clk(clk), .rst(rst), .rxLine(rxLine),
    .rxByte(rxByte), .byteValid(byteValid), .frameErr(frameErr), .breakPulse(breakPulse)
  );

  sbrx_top #(.BREAK_CLKS(COIN_BREAK)) dut2_i (
    .clk(clk), .rst(rst), .rxLine(rxLine),
    .rxByte(rxByte2), .byteValid(byteValid2), .frameErr(frameErr2), .breakPulse(breakPulse2)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic driveBit(input logic v);
    rxLine = v;
    repeat (BIT) @(negedge clk);
  endtask

  task automatic sendFrame(input logic [7:0] d, input logic stop1);
    expQ.push_back({~stop1, d});
    driveBit(1'b0);
    for (int i = 0; i < 8; i++) driveBit(d[i]);
    driveBit(stop1);
    driveBit(1'b1);
  endtask

  task automatic idle(input int n);
    rxLine = 1'b1;
    repeat (n) @(negedge clk);
  endtask

  task automatic holdLow(input int n);
    expQ.push_back({1'b1, 8'h00});
    rxLine = 1'b0;
    repeat (n) @(negedge clk);
    idle(300);
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      if (byteValid) begin
        validSeen++;
        if (expQ.size() == 0) begin
          check(1'b0, "R3", "unexpected byte", {23'd0, frameErr, rxByte}, 0);
        end else begin
          logic [8:0] e;
          e = expQ.pop_front();
          check({frameErr, rxByte} == e, e[8] ? "R4" : "R2", "byte/err",
                {23'd0, frameErr, rxByte}, {23'd0, e});
        end
      end
      if (breakPulse) breakSeen++;
      if (breakPulse2) begin
        break2Seen++;
        if (byteValid2) coinSeen++;
      end
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual 0x%0h expected 0x%0h", 1, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int v0, b0;
    repeat (5) @(negedge clk);
    // R1: reset state
    check(byteValid == 1'b0, "R1", "byteValid in reset", byteValid, 0);
    check(breakPulse == 1'b0, "R1", "breakPulse in reset", breakPulse, 0);
    rst = 1'b0;
    @(negedge clk);
    check(rxByte == 8'h00 && frameErr == 1'b0, "R1", "outputs after reset",
          {frameErr, rxByte}, 0);
    idle(50);

    // R2, R5: back-to-back frames with two stop bits
    sendFrame(8'h55, 1'b1);
    sendFrame(8'hA3, 1'b1);
    sendFrame(8'h00, 1'b1);
    sendFrame(8'hFF, 1'b1);
    sendFrame(8'h01, 1'b1);
    idle(100);
    check(validSeen == 5, "R5", "bytes received back to back", validSeen, 5);

    // R3: short glitch is not a start bit
    v0 = validSeen;
    rxLine = 1'b0;
    repeat (20) @(negedge clk);
    idle(1000);
    check(validSeen == v0, "R3", "glitch produced byte", validSeen, v0);

    // R4: low first stop bit, then hold of byte and flag
    sendFrame(8'hA5, 1'b0);
    idle(500);
    check(rxByte == 8'hA5 && frameErr == 1'b1, "R4", "held byte/flag",
          {frameErr, rxByte}, 9'h1A5);

    // R7, R8: low longer than a frame but below threshold
    b0 = breakSeen;
    v0 = validSeen;
    holdLow(800);
    check(breakSeen == b0, "R7", "break on short low", breakSeen, b0);
    check(validSeen == v0 + 1, "R8", "bytes from 800-cycle low", validSeen - v0, 1);

    // R6, R8: held-low reset pulse
    b0 = breakSeen;
    v0 = validSeen;
    holdLow(2000);
    check(breakSeen == b0 + 1, "R6", "break pulse count", breakSeen - b0, 1);
    check(validSeen == v0 + 1, "R8", "bytes from held reset", validSeen - v0, 1);

    // R8: reception resumes after release
    sendFrame(8'h3C, 1'b1);
    idle(200);
    check(rxByte == 8'h3C && frameErr == 1'b0, "R8", "recovery byte",
          {frameErr, rxByte}, 9'h03C);

    // R9: coincidence on the second instance
    check(break2Seen == 2, "R9", "coincident-instance breaks", break2Seen, 2);
    check(coinSeen == break2Seen, "R9", "break with byte same cycle", coinSeen, break2Seen);

    check(expQ.size() == 0, "R2", "bytes missing", expQ.size(), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule